// File: doc/BRIEF.md
# Processor Bus Slave Interface

This block is a synchronous slave on a processor-style memory bus. A bus master uses it to read and write a small file of 32-bit registers. Every bus input is sampled on the rising edge of the bus clock. A transfer opens with a one-cycle start strobe in the address phase. The strobe carries the direction, the transfer size, the burst flag and the byte address. The block then waits for both chip selects to be active. These are an active-low select and an active-high select, and both must be asserted while data moves. The block answers each data beat with a one-cycle acknowledge.

Each byte lane of the data bus carries its own even-parity bit. The block checks the parity on write data and generates it on read data. The last word of the register file is a status word: bit 0 records a write-parity error and bit 1 records a reserved size code. Both bits are sticky, and either one pulls the active-low interrupt low. Any error-free write to the status word clears both bits. Bursts are word transfers over incrementing word addresses. The master can shorten a burst by negating its burst-in-progress strobe.

Top module: `pbs_top`

## Requirements
- R1: After reset, ack is low, irq_n is high, and every register and the status word read as zero.
- R2: A beat is served only in a cycle where cs0_n is low and cs1 is high. While the selects are inactive or only half active, no ack is given and the transfer waits.
- R3: A read whose selects are already active in the start cycle acknowledges in the next cycle. Otherwise a beat acknowledges in the cycle after the first selected data-phase cycle, so a write acknowledges two cycles after its start at the earliest.
- R4: The size code decides which lanes a write updates, where lane k is data bits 8k+7:8k. Code 01 is a byte written to lane addr[1:0]. Code 10 is a half-word written to lanes 1:0 or 3:2, chosen by addr[1]. Code 00 is a word written to all four lanes. Address bits below the size are ignored.
- R5: A read returns the whole addressed word on rdata in the acknowledge cycle. Each rpar[k] makes lane k plus its parity bit hold an even count of ones.
- R6: If any enabled lane of a write fails even parity, the register is left unchanged and status bit 0 is set. The beat is still acknowledged. A parity error on a lane that the write does not enable has no effect.
- R7: Size code 11 is a bus error. The beat is acknowledged, nothing is written, a read returns zero, and status bit 1 is set.
- R8: irq_n is low while either status bit is set. A write to the status word (word index 7) that has no error of its own clears both bits.
- R9: A burst (burst_n low at start) serves beats at consecutive word addresses, one beat per selected cycle. It ends after 4 beats even if bdip_n stays low.
- R10: A beat served with bdip_n high is the last beat of a burst.
- R11: A transfer that starts with burst_n high serves exactly one beat, whatever the state of bdip_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| start | input | 1 | Address-phase strobe, one cycle per transfer |
| rd_wr | input | 1 | 1 = read, 0 = write |
| size | input | 2 | 01 byte, 10 half-word, 00 word, 11 reserved |
| burst_n | input | 1 | Low marks a burst transfer |
| bdip_n | input | 1 | Low requests further burst beats |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| wpar | input | 4 | Write parity, one bit per lane |
| rdata | output | 32 | Read data |
| rpar | output | 4 | Read parity, one bit per lane |
| ack | output | 1 | Beat acknowledge |
| irq_n | output | 1 | Bus-error interrupt, active low |

## Verification
The bench holds only one of the two selects active and looks for any ack. A design that decoded a single select would answer too early. It measures read latency with early and with late selects. An extra register on the early path, or a missing wait on the late one, moves the ack by one cycle. Byte and half-word writes go to distinct lanes, and the whole word is read back each time. A wrong size decode shows up as corrupted neighbouring bytes. Parity errors are placed on an enabled lane and on a disabled lane, which catches a checker that ignores lane enables. A four-beat burst is driven with bdip_n held low past its end, and a burst is cut short after its second beat. These tests expose an off-by-one beat limit, a missed abort, and a single transfer that runs on as a burst.

// File: rtl/pbs_pkg.sv
// pbs_pkg: shared constants, the size-code type and lane decoding for the
// processor bus slave. Assumes a fixed 32-bit word of four byte lanes.
package pbs_pkg;

    localparam int WORD_BYTES = 4;
    localparam int DATA_W     = WORD_BYTES * 8;
    localparam int LANE_W     = $clog2(WORD_BYTES);

    typedef enum logic [1:0] {
        SZ_WORD = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_HALF = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

    // Lane enables for a size code and the low address bits.
    function automatic logic [WORD_BYTES-1:0] lane_enables(input logic [1:0] sz,
                                                          input logic [LANE_W-1:0] lane);
        logic [WORD_BYTES-1:0] en;
        case (sz)
            SZ_BYTE: en = WORD_BYTES'(1) << lane;
            SZ_HALF: en = lane[1] ? 4'b1100 : 4'b0011;
            SZ_WORD: en = '1;
            default: en = '0;
        endcase
        return en;
    endfunction

endpackage

// File: rtl/pbs_parity.sv
// pbs_parity: even-parity bit for each byte lane of a word.
// Assumes the data width is a whole number of bytes.
module pbs_parity #(
    parameter int NBYTES = 4
) (
    input  logic [NBYTES*8-1:0] data,
    output logic [NBYTES-1:0]   par
);

    for (genvar i = 0; i < NBYTES; i++) begin : g_lane
        // One XOR tree per lane; the lane plus par[i] has an even count of ones.
        assign par[i] = ^data[i*8 +: 8];
    end

endmodule

// File: rtl/pbs_ctrl.sv
// pbs_ctrl: transfer sequencer. Captures the address phase and waits for
// both selects. It decides when a beat is served, counts burst beats and
// registers the acknowledge. Assumes start is high for one cycle per transfer.
module pbs_ctrl
    import pbs_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              start,
    input  logic              rd_wr,
    input  logic [1:0]        size,
    input  logic              burst_n,
    input  logic              bdip_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              fire,
    output logic              f_rd,
    output logic [1:0]        f_size,
    output logic [LANE_W-1:0] f_lane,
    output logic [ADDR_W-LANE_W-1:0] f_widx,
    output logic              ack
);

    localparam int WIDX_W = ADDR_W - LANE_W;
    localparam int BEAT_W = $clog2(BURST_LEN);

    typedef enum logic {ST_IDLE, ST_DATA} state_e;

    state_e              state_q;
    logic                rd_q, burst_q;
    logic [1:0]          size_q;
    logic [LANE_W-1:0]   lane_q;
    logic [WIDX_W-1:0]   base_q;
    logic [BEAT_W-1:0]   beat_q;
    logic                in_idle, eff_burst, last_beat;
    logic [WIDX_W-1:0]   eff_base;

    // Start cycle uses the live bus fields; later cycles use the captured ones.
    always_comb begin
        in_idle   = (state_q == ST_IDLE);
        f_rd      = in_idle ? rd_wr : rd_q;
        f_size    = in_idle ? size : size_q;
        f_lane    = in_idle ? addr[LANE_W-1:0] : lane_q;
        eff_base  = in_idle ? addr[ADDR_W-1:LANE_W] : base_q;
        eff_burst = in_idle ? !burst_n : burst_q;
        f_widx    = eff_base + WIDX_W'(beat_q);
        fire      = sel && (!in_idle || (start && rd_wr));
        last_beat = !eff_burst || bdip_n || (beat_q == BEAT_W'(BURST_LEN - 1));
    end

    // Sequencer state, captured address phase, beat counter and ack register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rd_q    <= 1'b0;
            burst_q <= 1'b0;
            size_q  <= 2'b00;
            lane_q  <= '0;
            base_q  <= '0;
            beat_q  <= '0;
            ack     <= 1'b0;
        end else begin
            ack <= fire;
            if (in_idle) begin
                if (start) begin
                    rd_q    <= rd_wr;
                    burst_q <= !burst_n;
                    size_q  <= size;
                    lane_q  <= addr[LANE_W-1:0];
                    base_q  <= addr[ADDR_W-1:LANE_W];
                    if (!fire) begin
                        state_q <= ST_DATA;
                    end else if (!last_beat) begin
                        state_q <= ST_DATA;
                        beat_q  <= beat_q + 1'b1;
                    end
                end
            end else if (fire) begin
                if (last_beat) begin
                    state_q <= ST_IDLE;
                    beat_q  <= '0;
                end else begin
                    beat_q  <= beat_q + 1'b1;
                end
            end
        end
    end

    // R10: a beat served with the strobe negated closes the burst.
    a_r10_abort_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && bdip_n) |=> (state_q == ST_IDLE));
    // R11: a non-burst transfer serves one beat only.
    a_r11_single_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !eff_burst) |=> (state_q == ST_IDLE));
    // R9: the final allowed beat always returns to idle.
    a_r9_burst_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && beat_q == BEAT_W'(BURST_LEN - 1)) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/pbs_regfile.sv
// pbs_regfile: word registers plus the sticky status word. A served beat
// writes the enabled lanes or captures read data. Parity and size errors
// are recorded. Assumes fire is high for exactly one cycle per beat.
module pbs_regfile
    import pbs_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              f_rd,
    input  logic [1:0]        f_size,
    input  logic [LANE_W-1:0] f_lane,
    input  logic [ADDR_W-LANE_W-1:0] f_widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [WORD_BYTES-1:0] wpar,
    output logic [DATA_W-1:0] rdata_q,
    output logic              par_err_q,
    output logic              size_err_q
);

    localparam int WIDX_W     = ADDR_W - LANE_W;
    localparam int NREGS      = 2 ** WIDX_W;
    localparam int STATUS_IDX = NREGS - 1;

    logic [DATA_W-1:0]     mem_q [NREGS];
    logic [WORD_BYTES-1:0] calc_par, lane_en;
    logic                  size_bad, par_bad, is_status, wr_ok;

    pbs_parity #(.NBYTES(WORD_BYTES)) u_wpar (.data(wdata), .par(calc_par));

    // Decode lanes and classify the beat's errors.
    always_comb begin
        lane_en   = lane_enables(f_size, f_lane);
        size_bad  = (f_size == SZ_RSVD);
        par_bad   = |((wpar ^ calc_par) & lane_en);
        is_status = (f_widx == WIDX_W'(STATUS_IDX));
        wr_ok     = fire && !f_rd && !size_bad && !par_bad;
    end

    // Register storage, read capture and sticky status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NREGS; r++) mem_q[r] <= '0;
            rdata_q    <= '0;
            par_err_q  <= 1'b0;
            size_err_q <= 1'b0;
        end else if (fire) begin
            if (f_rd) begin
                if (size_bad)       rdata_q <= '0;
                else if (is_status) rdata_q <= {{(DATA_W-2){1'b0}}, size_err_q, par_err_q};
                else                rdata_q <= mem_q[f_widx];
            end
            if (size_bad) begin
                size_err_q <= 1'b1;
            end else if (!f_rd && par_bad) begin
                par_err_q <= 1'b1;
            end else if (wr_ok && is_status) begin
                par_err_q  <= 1'b0;
                size_err_q <= 1'b0;
            end else if (wr_ok) begin
                for (int b = 0; b < WORD_BYTES; b++)
                    if (lane_en[b]) mem_q[f_widx][b*8 +: 8] <= wdata[b*8 +: 8];
            end
        end
    end

    // R6: a write parity error is recorded.
    a_r6_parity_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !f_rd && !size_bad && par_bad) |=> par_err_q);
    // R7: a reserved size code is recorded.
    a_r7_size_error: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && size_bad) |=> size_err_q);
    // R8: a clean status write clears both bits.
    a_r8_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && is_status) |=> (!par_err_q && !size_err_q));

endmodule

// File: rtl/pbs_top.sv
// pbs_top: processor bus slave. Decodes the two chip selects and joins the
// sequencer, the register file and the read-parity generator.
// Assumes all inputs are synchronous to clk.
module pbs_top
    import pbs_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs0_n,
    input  logic              cs1,
    input  logic              start,
    input  logic              rd_wr,
    input  logic [1:0]        size,
    input  logic              burst_n,
    input  logic              bdip_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [3:0]        wpar,
    output logic [31:0]       rdata,
    output logic [3:0]        rpar,
    output logic              ack,
    output logic              irq_n
);

    logic                  sel, fire, f_rd, par_err, size_err;
    logic [1:0]            f_size;
    logic [LANE_W-1:0]     f_lane;
    logic [ADDR_W-LANE_W-1:0] f_widx;

    // Both selects must be asserted together.
    assign sel   = !cs0_n && cs1;
    assign irq_n = !(par_err || size_err);

    pbs_ctrl #(.ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sel(sel), .start(start), .rd_wr(rd_wr),
        .size(size), .burst_n(burst_n), .bdip_n(bdip_n), .addr(addr),
        .fire(fire), .f_rd(f_rd), .f_size(f_size), .f_lane(f_lane),
        .f_widx(f_widx), .ack(ack));

    pbs_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .fire(fire), .f_rd(f_rd), .f_size(f_size),
        .f_lane(f_lane), .f_widx(f_widx), .wdata(wdata), .wpar(wpar),
        .rdata_q(rdata), .par_err_q(par_err), .size_err_q(size_err));

    pbs_parity #(.NBYTES(WORD_BYTES)) u_rpar (.data(rdata), .par(rpar));

    // R2: every acknowledge follows a fully selected cycle.
    a_r2_ack_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(!cs0_n && cs1));

endmodule

// File: tb/pbs_top_tb.sv
// Directed bench for pbs_top: one task per scenario, each checks its own results.
module pbs_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs0_n = 1'b1, cs1 = 1'b0, start = 1'b0, rd_wr = 1'b1;
    logic [1:0]  size = 2'b00;
    logic        burst_n = 1'b1, bdip_n = 1'b1;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  wpar = '0;
    logic [31:0] rdata;
    logic [3:0]  rpar;
    logic        ack, irq_n;
    int          n_chk = 0, n_bad = 0;

    pbs_top dut_i (.clk(clk), .rst_n(rst_n), .cs0_n(cs0_n), .cs1(cs1),
        .start(start), .rd_wr(rd_wr), .size(size), .burst_n(burst_n),
        .bdip_n(bdip_n), .addr(addr), .wdata(wdata), .wpar(wpar),
        .rdata(rdata), .rpar(rpar), .ack(ack), .irq_n(irq_n));

    always #10 clk = ~clk;

    function automatic logic [3:0] even_par(input logic [31:0] d);
        for (int i = 0; i < 4; i++) even_par[i] = ^d[i*8 +: 8];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Advance to just after the next rising edge.
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic select(input logic on);
        cs0_n = !on;
        cs1   = on;
    endtask

    // Single write; the selects are held one cycle past the ack.
    task automatic wr(input logic [4:0] a, input logic [1:0] sz, input logic [31:0] d,
                      input logic [3:0] par_flip, input string req);
        start = 1; rd_wr = 0; size = sz; addr = a; wdata = d;
        wpar = even_par(d) ^ par_flip; select(1);
        tick(); start = 0;
        check({req, " no ack in start cycle"}, ack, 0);
        tick(); check({req, " write ack"}, ack, 1);
        tick(); check({req, " one beat only"}, ack, 0);
        select(0);
    endtask

    // Single read; early selects give the one-cycle path (R3).
    task automatic rd(input logic [4:0] a, input logic [1:0] sz, input logic early,
                      input logic [31:0] exp, input string req);
        start = 1; rd_wr = 1; size = sz; addr = a; select(early);
        tick(); start = 0;
        if (!early) begin
            check("R3 late read waits", ack, 0);
            select(1); tick();
        end
        check({req, " read ack"}, ack, 1);
        check({req, " read data"}, rdata, exp);
        check("R5 read parity", rpar, even_par(exp));
        select(0); tick();
        check({req, " ack drops"}, ack, 0);
    endtask

    task automatic t_reset();
        check("R1 ack after reset", ack, 0);
        check("R1 irq after reset", irq_n, 1);
        rd(5'h00, 2'b00, 1, 32'h0, "R1");
        rd(5'h1C, 2'b00, 1, 32'h0, "R1 status");
    endtask

    // R2: half-active selects must not serve the beat.
    task automatic t_select();
        start = 1; rd_wr = 1; size = 2'b00; addr = 5'h00; cs0_n = 0; cs1 = 0;
        tick(); start = 0;
        check("R2 cs1 low", ack, 0);
        cs0_n = 1; cs1 = 1; tick();
        check("R2 cs0_n high", ack, 0);
        tick(); check("R2 still waiting", ack, 0);
        select(1); tick();
        check("R2 served once selected", ack, 1);
        select(0); tick();
    endtask

    task automatic t_lanes();
        wr(5'h18, 2'b00, 32'h11223344, 4'h0, "R4 word");
        wr(5'h1A, 2'b01, 32'h00AA0000, 4'h0, "R4 byte");
        rd(5'h18, 2'b00, 0, 32'h11AA3344, "R4 byte lane 2");
        wr(5'h19, 2'b10, 32'h0000BEEF, 4'h0, "R4 half");
        rd(5'h18, 2'b00, 1, 32'h11AABEEF, "R4 half low");
        wr(5'h1A, 2'b10, 32'hCAFE0000, 4'h0, "R4 half high");
        rd(5'h18, 2'b01, 1, 32'hCAFEBEEF, "R5 full word on byte read");
    endtask

    task automatic t_parity();
        wr(5'h18, 2'b01, 32'h00000077, 4'h8, "R6 bad parity on idle lane");
        check("R6 idle-lane error ignored", irq_n, 1);
        rd(5'h18, 2'b00, 1, 32'hCAFEBE77, "R6 idle lane written");
        wr(5'h19, 2'b01, 32'h00005500, 4'h2, "R6 bad parity");
        check("R6/R8 irq low", irq_n, 0);
        rd(5'h18, 2'b00, 1, 32'hCAFEBE77, "R6 no write");
        rd(5'h1C, 2'b00, 1, 32'h1, "R6 status bit0");
        wr(5'h1C, 2'b00, 32'h0, 4'h0, "R8 clear");
        check("R8 irq released", irq_n, 1);
        rd(5'h1C, 2'b00, 1, 32'h0, "R8 status cleared");
    endtask

    task automatic t_size();
        wr(5'h00, 2'b11, 32'hFFFFFFFF, 4'h0, "R7 reserved size");
        check("R7 irq low", irq_n, 0);
        rd(5'h00, 2'b00, 1, 32'h0, "R7 no write");
        rd(5'h1C, 2'b00, 1, 32'h2, "R7 status bit1");
        rd(5'h00, 2'b11, 1, 32'h0, "R7 reserved read returns zero");
        wr(5'h1C, 2'b00, 32'h0, 4'h0, "R8 clear size error");
        check("R8 irq released after size error", irq_n, 1);
    endtask

    // R9: four-beat write burst; bdip_n stays low past the end.
    task automatic t_burst();
        start = 1; rd_wr = 0; size = 2'b00; addr = 5'h04; burst_n = 0; bdip_n = 0;
        wdata = 32'hA0000001; wpar = even_par(wdata); select(1);
        tick(); start = 0;
        check("R9 no ack in start cycle", ack, 0);
        for (int k = 0; k < 4; k++) begin
            tick();
            check("R9 burst beat ack", ack, 1);
            wdata = 32'hA0000002 + k; wpar = even_par(wdata);
        end
        tick(); check("R9 burst stops after 4 beats", ack, 0);
        select(0); burst_n = 1; bdip_n = 1; tick();
        for (int k = 0; k < 4; k++)
            rd(5'(4 + 4*k), 2'b00, 1, 32'hA0000001 + k, "R9 burst data");
        rd(5'h14, 2'b00, 1, 32'h0, "R9 fifth word untouched");
    endtask

    // R10: read burst cut short after its second beat.
    task automatic t_abort();
        start = 1; rd_wr = 1; size = 2'b00; addr = 5'h08; burst_n = 0; bdip_n = 0; select(1);
        tick(); start = 0;
        check("R10 beat 0 ack", ack, 1);
        check("R10 beat 0 data", rdata, 32'hA0000002);
        bdip_n = 1; tick();
        check("R10 beat 1 ack", ack, 1);
        check("R10 beat 1 data", rdata, 32'hA0000003);
        tick(); check("R10 burst aborted", ack, 0);
        select(0); burst_n = 1; tick();
    endtask

    // R11: non-burst write with the strobe held low serves one beat.
    task automatic t_single();
        bdip_n = 0;
        wr(5'h00, 2'b00, 32'h5A5A5A5A, 4'h0, "R11 single with strobe low");
        bdip_n = 1;
        rd(5'h04, 2'b00, 1, 32'hA0000001, "R11 next word untouched");
        rd(5'h00, 2'b00, 1, 32'h5A5A5A5A, "R11 single written");
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset();
        t_select();
        t_lanes();
        t_parity();
        t_size();
        t_burst();
        t_abort();
        t_single();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(20 * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule